// File: doc/BRIEF.md
# Round-Robin Channel Byte Scheduler

This block is the shared data mover of an I/O channel serving several device ports. Each port raises a request flag while it holds a byte to send, and it shows that byte on its data lane. The scheduler picks one port at a time in round-robin order. It forwards that port's bytes onto a single downstream byte stream, with each byte tagged by its source port index, and it pulses an acknowledge back to the port for every byte taken.

Three service disciplines share one arbiter. In exclusive mode the chosen device keeps the channel until it has nothing left to send, which suits fast devices. In single-byte interleave mode each device sends one byte per turn, which suits slow devices. In burst interleave mode each device sends up to a programmable number of bytes per turn. The mode and the burst length are sampled only when a turn is granted, so changing them never disturbs a turn already under way. A downstream ready signal stalls the stream without losing the place in the rotation.

Top module: `rr_channel_sched`

## Requirements
- R1: While reset is asserted and after reset with no requests, `out_valid_o` is 0 and `dev_ack_o` is all zero.
- R2: While `out_valid_o` is 1, `out_port_o` names a requesting port and `out_data_o` equals that port's data lane (lane p occupies bits p*DW+DW-1 down to p*DW). A byte moves when `out_valid_o` and `out_ready_i` are both 1, and in that cycle only bit `out_port_o` of `dev_ack_o` is 1.
- R3: A new turn goes to the first requesting port found by searching upward, with wrap-around, from the port after the one whose turn ended last. Ports without a request are skipped. After reset the search starts at port 0.
- R4: With `mode_i` = 1 (single-byte interleave), a turn moves exactly one byte.
- R5: With `mode_i` = 2 (burst interleave), a turn moves up to `quantum_i` bytes, and a quantum of 0 behaves as 1.
- R6: In burst interleave mode, a port that drops its request before its quantum is used ends its turn early, and the rotation moves on.
- R7: With `mode_i` = 0 (exclusive), the granted port keeps the channel for as long as its request stays high.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, no byte is acknowledged and `out_port_o` and `out_data_o` hold. The rotation order is unchanged by stalls.
- R9: `mode_i` and `quantum_i` are captured when a turn is granted. A change during a turn takes effect from the next turn.
- R10: `mode_i` = 3 behaves as single-byte interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Service mode: 0 exclusive, 1 byte interleave, 2 burst interleave, 3 byte interleave |
| quantum_i | input | KW | Bytes per turn in burst interleave mode |
| dev_req_i | input | N_PORTS | Per-port request: a byte is available on the lane |
| dev_data_i | input | N_PORTS*DW | Packed per-port data lanes |
| dev_ack_o | output | N_PORTS | Per-port byte-taken pulse |
| out_valid_o | output | 1 | Downstream byte valid |
| out_data_o | output | DW | Downstream byte |
| out_port_o | output | $clog2(N_PORTS) | Source port index of the downstream byte |
| out_ready_i | input | 1 | Downstream ready |

## Verification
The hardest case to reach from the ports is a change of burst length that arrives while a burst turn is partway through. The old length must finish that turn and the new one must govern the next turns. The stimulus waits until the monitor has seen the first byte of a four-byte turn, lowers the quantum to 1, and expects the remaining bytes of that turn followed by strict one-byte alternation. A further run with random downstream stalls checks that held bytes do not change and that the interleaving order is the same as it is without stalls.

// File: rtl/rrch_pkg.sv
package rrch_pkg;
   typedef enum logic [1:0] {
      CH_EXCL     = 2'd0,
      CH_BYTE     = 2'd1,
      CH_BURST    = 2'd2,
      CH_BYTE_ALT = 2'd3
   } ch_mode_e;
endpackage

// File: rtl/rrch_pick.sv
module rrch_pick #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   input  logic [IW-1:0] last_i,
   output logic          hit_o,
   output logic [IW-1:0] pick_o
);
   localparam bit IS_POW2 = (N == (1 << IW));

   logic [IW-1:0] cand [N];

   // candidate k holds the port at distance k+1 after last_i
   generate
      if (IS_POW2) begin : g_wrap
         for (genvar k = 0; k < N; k++) begin : g_c
            assign cand[k] = last_i + IW'(k + 1);
         end
      end else begin : g_mod
         for (genvar k = 0; k < N; k++) begin : g_c
            assign cand[k] = IW'((int'(last_i) + k + 1) % N);
         end
      end
   endgenerate

   always_comb begin
      hit_o  = 1'b0;
      pick_o = '0;
      for (int k = 0; k < N; k++) begin
         if (!hit_o && req_i[cand[k]]) begin
            hit_o  = 1'b1;
            pick_o = cand[k];
         end
      end
   end
endmodule

// File: rtl/rrch_quota.sv
module rrch_quota
   import rrch_pkg::*;
#(
   parameter int KW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [1:0]    mode_i,
   input  logic [KW-1:0] quantum_i,
   input  logic          fire_i,
   output logic          full_o,
   output ch_mode_e      mode_o,
   output logic [KW-1:0] k_o
);
   ch_mode_e      mode_q;
   logic [KW-1:0] k_q;
   logic [KW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= CH_BYTE;
         k_q    <= KW'(1);
         cnt_q  <= '0;
      end else if (load_i) begin
         mode_q <= ch_mode_e'(mode_i);
         k_q    <= (quantum_i == '0) ? KW'(1) : quantum_i;
         cnt_q  <= '0;
      end else if (fire_i) begin
         cnt_q  <= cnt_q + KW'(1);
      end
   end

   always_comb begin
      unique case (mode_q)
         CH_EXCL:  full_o = 1'b0;
         CH_BURST: full_o = fire_i && (cnt_q == k_q - KW'(1));
         default:  full_o = fire_i;
      endcase
   end

   assign mode_o = mode_q;
   assign k_o    = k_q;
endmodule

// File: rtl/rr_channel_sched.sv
module rr_channel_sched
   import rrch_pkg::*;
#(
   parameter int N_PORTS = 4,
   parameter int DW      = 8,
   parameter int KW      = 4,
   localparam int IW     = $clog2(N_PORTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            mode_i,
   input  logic [KW-1:0]         quantum_i,
   input  logic [N_PORTS-1:0]    dev_req_i,
   input  logic [N_PORTS*DW-1:0] dev_data_i,
   output logic [N_PORTS-1:0]    dev_ack_o,
   output logic                  out_valid_o,
   output logic [DW-1:0]         out_data_o,
   output logic [IW-1:0]         out_port_o,
   input  logic                  out_ready_i
);
   if (N_PORTS < 2) begin : g_bad_ports
      $error("rr_channel_sched: N_PORTS must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rr_channel_sched: DW must be positive");
   end
   if (KW < 1) begin : g_bad_kw
      $error("rr_channel_sched: KW must be positive");
   end

   logic          active_q;
   logic [IW-1:0] cur_q;
   logic [IW-1:0] last_q;
   logic          hit;
   logic [IW-1:0] pick;
   logic          load;
   logic          cur_req;
   logic          fire;
   logic          turn_full;
   logic          end_turn;
   ch_mode_e      turn_mode;
   logic [KW-1:0] turn_k;
   logic [DW-1:0] lane [N_PORTS];

   for (genvar p = 0; p < N_PORTS; p++) begin : g_lane
      assign lane[p] = dev_data_i[p*DW +: DW];
   end

   rrch_pick #(.N(N_PORTS), .IW(IW)) u_pick (
      .req_i  (dev_req_i),
      .last_i (last_q),
      .hit_o  (hit),
      .pick_o (pick)
   );

   assign load    = !active_q && hit;
   assign cur_req = dev_req_i[cur_q];
   assign fire    = active_q && cur_req && out_ready_i;

   rrch_quota #(.KW(KW)) u_quota (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .mode_i    (mode_i),
      .quantum_i (quantum_i),
      .fire_i    (fire),
      .full_o    (turn_full),
      .mode_o    (turn_mode),
      .k_o       (turn_k)
   );

   assign end_turn = active_q && (!cur_req || turn_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cur_q    <= '0;
         last_q   <= IW'(N_PORTS - 1);
      end else if (load) begin
         active_q <= 1'b1;
         cur_q    <= pick;
      end else if (end_turn) begin
         active_q <= 1'b0;
         last_q   <= cur_q;
      end
   end

   assign out_valid_o = active_q && cur_req;
   assign out_data_o  = lane[cur_q];
   assign out_port_o  = cur_q;

   always_comb begin
      dev_ack_o = '0;
      if (fire) dev_ack_o[cur_q] = 1'b1;
   end
endmodule

// File: rtl/rrch_checker.sv
module rrch_checker
   import rrch_pkg::*;
#(
   parameter int N_PORTS = 4,
   parameter int KW      = 4,
   parameter int IW      = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_PORTS-1:0] dev_req_i,
   input logic [N_PORTS-1:0] dev_ack_o,
   input logic               out_valid_o,
   input logic [IW-1:0]      out_port_o,
   input logic               out_ready_i,
   input logic               active_q,
   input ch_mode_e           turn_mode,
   input logic [KW-1:0]      turn_k
);
   logic          fire_w;
   logic [KW:0]   beats_q;

   assign fire_w = out_valid_o && out_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             beats_q <= '0;
      else if (!active_q)     beats_q <= '0;
      else if (fire_w)        beats_q <= beats_q + 1'b1;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!out_valid_o && dev_ack_o == '0);
      end
   end

   p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_ack_o));

   p_ack_on_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ack_o != '0) |-> (fire_w && dev_ack_o[out_port_o]));

   p_valid_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> dev_req_i[out_port_o]);

   p_byte_turn_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_w && (turn_mode == CH_BYTE || turn_mode == CH_BYTE_ALT)) |=> !out_valid_o);

   p_burst_within_quota_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_w && turn_mode == CH_BURST) |-> (beats_q < {1'b0, turn_k}));

   p_excl_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && turn_mode == CH_EXCL) |=> (active_q && $stable(out_port_o)));

   p_stall_keeps_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> $stable(out_port_o));

   p_mode_fixed_in_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q)) |-> ($stable(turn_mode) && $stable(turn_k)));
endmodule

bind rr_channel_sched rrch_checker #(
   .N_PORTS (N_PORTS),
   .KW      (KW),
   .IW      (IW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dev_req_i   (dev_req_i),
   .dev_ack_o   (dev_ack_o),
   .out_valid_o (out_valid_o),
   .out_port_o  (out_port_o),
   .out_ready_i (out_ready_i),
   .active_q    (active_q),
   .turn_mode   (turn_mode),
   .turn_k      (turn_k)
);

// File: tb/sim_rr_channel_sched.sv
module sim_rr_channel_sched;
   localparam int NP = 4;
   localparam int DW = 8;
   localparam int KW = 4;
   localparam int IW = 2;

   typedef struct {
      int          port;
      logic [7:0]  d;
      string       tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [1:0]         mode = 2'd1;
   logic [KW-1:0]      quantum = KW'(1);
   logic [NP-1:0]      req = '0;
   logic [NP*DW-1:0]   data = '0;
   logic [NP-1:0]      ack;
   logic               out_valid;
   logic [DW-1:0]      out_data;
   logic [IW-1:0]      out_port;
   logic               out_ready = 1'b1;

   logic [7:0]         dq [NP][$];
   exp_t               expq [$];
   logic [NP-1:0]      ack_s = '0;
   bit                 stall_en = 0;
   int                 n_cmp = 0;
   int                 n_bad = 0;
   int                 n_fire = 0;
   int                 mlast = NP - 1;
   bit                 prev_stall = 0;
   logic [IW-1:0]      prev_port;
   logic [7:0]         prev_data;

   always #2 clk = ~clk;

   rr_channel_sched #(.N_PORTS(NP), .DW(DW), .KW(KW)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .quantum_i   (quantum),
      .dev_req_i   (req),
      .dev_data_i  (data),
      .dev_ack_o   (ack),
      .out_valid_o (out_valid),
      .out_data_o  (out_data),
      .out_port_o  (out_port),
      .out_ready_i (out_ready)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic void refresh();
      for (int p = 0; p < NP; p++) begin
         req[p] = (dq[p].size() != 0);
         data[p*DW +: DW] = req[p] ? dq[p][0] : 8'h00;
      end
   endfunction

   function automatic logic [7:0] mk(input int p, input int scn, input int seq);
      return 8'((p << 6) | (scn << 3) | seq);
   endfunction

   // device models: pop the acknowledged byte just after the edge
   always @(posedge clk) begin
      #1;
      for (int p = 0; p < NP; p++) if (ack_s[p]) void'(dq[p].pop_front());
      refresh();
      out_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
   end

   // monitor: sample away from the active edge
   always @(negedge clk) begin
      ack_s = ack;
      if (rst_n) begin
         if (prev_stall) begin
            check(out_valid && out_port == prev_port && out_data == prev_data,
                  "R8", "held byte changed (port)", int'(out_port), int'(prev_port));
         end
         if (out_valid && out_ready) begin
            exp_t e;
            n_fire++;
            check(ack == (NP'(1) << out_port), "R2", "ack vector",
                  int'(ack), int'(NP'(1) << out_port));
            if (expq.size() == 0) begin
               check(0, "R2", "unexpected byte", int'(out_data), -1);
            end else begin
               e = expq.pop_front();
               check(int'(out_port) == e.port, e.tag, "source port", int'(out_port), e.port);
               check(out_data == e.d, e.tag, "data byte", int'(out_data), int'(e.d));
            end
         end else if (!out_valid) begin
            check(ack == '0, "R2", "ack without transfer", int'(ack), 0);
         end
         prev_stall = out_valid && !out_ready;
         prev_port  = out_port;
         prev_data  = out_data;
      end
   end

   // reference: expected order from the requirements
   task automatic model(input int L[NP], input int md, input int k,
                        input int scn, input string tag);
      int rem [NP];
      int left = 0;
      for (int p = 0; p < NP; p++) begin rem[p] = L[p]; left += L[p]; end
      while (left > 0) begin
         int p = mlast;
         int n;
         for (int s = 1; s <= NP; s++) begin
            p = (mlast + s) % NP;
            if (rem[p] > 0) break;
         end
         if (md == 0)      n = rem[p];
         else if (md == 2) n = (((k == 0) ? 1 : k) < rem[p]) ? ((k == 0) ? 1 : k) : rem[p];
         else              n = 1;
         for (int j = 0; j < n; j++) begin
            expq.push_back('{p, mk(p, scn, L[p] - rem[p]), tag});
            rem[p]--;
            left--;
         end
         mlast = p;
      end
   endtask

   task automatic load(input int L[NP], input int scn);
      @(posedge clk); #2;
      for (int p = 0; p < NP; p++)
         for (int s = 0; s < L[p]; s++) dq[p].push_back(mk(p, scn, s));
      refresh();
   endtask

   task automatic drain();
      while (expq.size() != 0) @(posedge clk);
      repeat (4) @(posedge clk);
   endtask

   task automatic scenario(input int L[NP], input int md, input int k,
                           input int scn, input string tag);
      @(posedge clk); #2;
      mode = 2'(md);
      quantum = KW'(k);
      model(L, md, k, scn, tag);
      load(L, scn);
      drain();
   endtask

   initial begin
      int wd = 0;
      while (wd < 100000) begin @(posedge clk); wd++; end
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!out_valid && ack == '0, "R1", "outputs in reset", int'(out_valid), 0);
      @(posedge clk); #2 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!out_valid && ack == '0, "R1", "idle after reset", int'(out_valid), 0);

      // R3 R4: byte interleave, idle port skipped, search starts at port 0
      scenario('{3, 0, 2, 1}, 1, 1, 0, "R4");
      // R3: rotation resumes after last served port
      scenario('{1, 2, 0, 2}, 1, 1, 1, "R3");
      // R5: burst interleave, quantum 3
      scenario('{5, 2, 0, 4}, 2, 3, 2, "R5");
      // R6: request drops before quantum is used
      scenario('{2, 3, 0, 0}, 2, 4, 3, "R6");
      // R7: exclusive mode holds the channel
      scenario('{3, 2, 4, 0}, 0, 1, 4, "R7");
      // R10: mode 3 acts as byte interleave
      scenario('{2, 2, 0, 1}, 3, 5, 5, "R10");
      // R5: quantum 0 behaves as 1
      scenario('{2, 2, 0, 0}, 2, 0, 6, "R5");

      // R9: quantum lowered partway through a 4-byte turn
      begin
         int a = (mlast + 1) % NP;
         int b = (mlast + 2) % NP;
         int L [NP];
         int c0;
         int ia = 0;
         int ib = 0;
         for (int p = 0; p < NP; p++) L[p] = (p == a || p == b) ? 6 : 0;
         @(posedge clk); #2;
         mode = 2'd2;
         quantum = KW'(4);
         for (int j = 0; j < 4; j++) begin expq.push_back('{a, mk(a, 7, ia), "R9"}); ia++; end
         for (int j = 0; j < 2; j++) begin
            expq.push_back('{b, mk(b, 7, ib), "R9"}); ib++;
            expq.push_back('{a, mk(a, 7, ia), "R9"}); ia++;
         end
         while (ib < 6) begin expq.push_back('{b, mk(b, 7, ib), "R9"}); ib++; end
         mlast = b;
         c0 = n_fire;
         load(L, 7);
         while (n_fire == c0) @(posedge clk);
         #2 quantum = KW'(1);
         drain();
      end

      // R8: same interleaving under random downstream stalls
      stall_en = 1;
      scenario('{4, 3, 0, 5}, 2, 2, 1, "R8");
      scenario('{2, 2, 3, 0}, 1, 1, 2, "R8");
      stall_en = 0;
      repeat (4) @(posedge clk);

      @(negedge clk);
      check(!out_valid && ack == '0, "R1", "idle at end", int'(out_valid), 0);
      check(expq.size() == 0, "R2", "bytes left unsent", expq.size(), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule